// File: doc/BRIEF.md
# Nibble-Wide Per-Port Cell Interface

This block moves fixed-size cells between a set of cell buffers and a far device over narrow, dedicated per-port links. Each port has its own 4-bit transmit bus, its own 4-bit receive bus, and a frame line in each direction. Every transfer is a one-cycle strobe that is synchronous to one shared free-running source clock.

On transmit, the block produces a per-port transfer strobe from the source clock. The strobe runs only while the port's transmit buffer has room for a whole cell. On each strobe the far device either raises the frame line, which marks the slot just before a cell, or it presents a nibble. The block rebuilds bytes from the nibbles, high nibble first, and hands them to the buffer marked with start and end of cell. A frame that arrives partway through a cell abandons that cell and starts a new one.

On receive, the far device pulses a pull line each time it can take a nibble. Once the buffer reports a whole cell, the next pull produces a one-cycle frame pulse. The pulls after that walk the cell out nibble by nibble, high nibble first, and pop bytes from the buffer.

Top module: `nibble_cell_if`

## Requirements
- R1: While reset is held, every output is 0. After reset, `tx_xclk[p]` is 1 in a cycle exactly when `tx_room[p]` was 1 in the previous cycle.
- R2: After a frame slot, each pair of strobe nibbles forms one byte, with the first nibble in bits 7:4. The byte appears on `txc_byte` with `txc_we` high for one cycle, in the cycle after the strobe that carried the second nibble.
- R3: `txc_sop` marks the first byte of a cell and `txc_eop` marks byte CELL_BYTES of that cell. Both are valid only with `txc_we`. After the last byte the port waits for a new frame.
- R4: Nibbles that arrive on strobes while the port is not inside a cell, with no frame seen since the last complete cell, produce no byte.
- R5: A frame on a strobe after at least one nibble of a cell gives a one-cycle `txc_abort` in the next cycle. The partial cell produces no further bytes, and the nibble count restarts from the next strobe. A frame that comes right after another frame gives no abort.
- R6: `tx_td` and `tx_sync` are ignored in cycles where `tx_xclk` is 0.
- R7: A pull while `rxc_avail[p]` is 0 and no cell is in progress leaves `rx_sync` at 0 and `rx_nib` unchanged.
- R8: The first pull that comes with `rxc_avail[p]` high while idle makes `rx_sync` 1 for exactly the next cycle, with `rx_nib` set to 0.
- R9: Each of the next 2*CELL_BYTES pulls presents one nibble of the current `rxc_byte` on `rx_nib` in the following cycle, high nibble first. `rxc_pop` is high during the pull that takes the low nibble, and at no other time. After the last nibble the port is idle again.
- R10: `rx_nib` changes only in the cycle after a pull, and `rx_sync` is never high in two consecutive cycles.
- R11: Each port's transmit and receive behaviour is independent of every other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_room | input | NPORTS | Transmit buffer of port p can take a whole cell |
| tx_xclk | output | NPORTS | Per-port transmit transfer strobe |
| tx_td | input | 4*NPORTS | Transmit nibble, port p in bits 4p+3:4p |
| tx_sync | input | NPORTS | Transmit frame, slot before a cell |
| txc_we | output | NPORTS | Byte write toward transmit buffer |
| txc_byte | output | 8*NPORTS | Rebuilt byte, port p in bits 8p+7:8p |
| txc_sop | output | NPORTS | Byte is first of its cell |
| txc_eop | output | NPORTS | Byte is last of its cell |
| txc_abort | output | NPORTS | Partial cell discarded |
| rx_pull | input | NPORTS | Far device ready for a receive nibble |
| rx_nib | output | 4*NPORTS | Receive nibble, port p in bits 4p+3:4p |
| rx_sync | output | NPORTS | Receive frame, one cycle before a cell |
| rxc_avail | input | NPORTS | Receive buffer holds a whole cell |
| rxc_byte | input | 8*NPORTS | Head byte of receive buffer |
| rxc_pop | output | NPORTS | Consume head byte |

## Verification
The bench builds the block with NPORTS = 3 and CELL_BYTES = 3, so a cell is six nibbles long. With cells that short, random frames regularly land inside a cell, right after another frame, and exactly on the last nibble. Receive cells also start back to back within a few pulls. Using three ports lets the ports run at different stall and pull rates and shows that they do not interfere with one another.

// File: rtl/nci_pkg.sv
package nci_pkg;
  typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_ARMED = 2'd1, TX_BODY = 2'd2} tx_st_e;
  typedef enum logic {RX_IDLE = 1'b0, RX_BODY = 1'b1} rx_st_e;
endpackage

// File: rtl/nci_rst_sync.sv
module nci_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/nci_tx_port.sv
module nci_tx_port #(
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       room,
  input  logic [3:0] td,
  input  logic       sync,
  output logic       xclk,
  output logic       we,
  output logic [7:0] data,
  output logic       sop,
  output logic       eop,
  output logic       abort
);
  import nci_pkg::*;
  localparam int NIBS = 2 * CELL_BYTES;
  localparam int CW = (NIBS > 2) ? $clog2(NIBS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIBS - 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  tx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    hi_q, hi_d;
  logic          xclk_q, we_q, we_d, sop_q, sop_d, eop_q, eop_d, ab_q, ab_d;
  logic [7:0]    data_q, data_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    data_d = data_q;
    we_d   = 1'b0;
    sop_d  = 1'b0;
    eop_d  = 1'b0;
    ab_d   = 1'b0;
    if (xclk_q) begin
      if (sync) begin
        ab_d  = (st_q == TX_BODY);
        st_d  = TX_ARMED;
        cnt_d = '0;
      end else if (st_q != TX_IDLE) begin
        if (!cnt_q[0]) begin
          hi_d = td;
        end else begin
          we_d   = 1'b1;
          data_d = {hi_q, td};
          sop_d  = (cnt_q == ONE);
          eop_d  = (cnt_q == LAST);
        end
        if (cnt_q == LAST) begin
          st_d  = TX_IDLE;
          cnt_d = '0;
        end else begin
          st_d  = TX_BODY;
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xclk_q <= 1'b0;
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      hi_q   <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      ab_q   <= 1'b0;
    end else begin
      xclk_q <= room;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
      data_q <= data_d;
      we_q   <= we_d;
      sop_q  <= sop_d;
      eop_q  <= eop_d;
      ab_q   <= ab_d;
    end
  end

  assign xclk  = xclk_q;
  assign we    = we_q;
  assign data  = data_q;
  assign sop   = sop_q;
  assign eop   = eop_q;
  assign abort = ab_q;
endmodule

// File: rtl/nci_rx_port.sv
module nci_rx_port #(
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pull,
  input  logic       avail,
  input  logic [7:0] head,
  output logic [3:0] nib,
  output logic       sync,
  output logic       pop
);
  import nci_pkg::*;
  localparam int NIBS = 2 * CELL_BYTES;
  localparam int CW = (NIBS > 2) ? $clog2(NIBS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIBS - 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  rx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    nib_q, nib_d;
  logic          sync_q, sync_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    nib_d  = nib_q;
    sync_d = 1'b0;
    pop    = 1'b0;
    if (pull) begin
      if (st_q == RX_IDLE) begin
        if (avail) begin
          sync_d = 1'b1;
          nib_d  = '0;
          st_d   = RX_BODY;
          cnt_d  = '0;
        end
      end else begin
        nib_d = cnt_q[0] ? head[3:0] : head[7:4];
        pop   = cnt_q[0];
        if (cnt_q == LAST) begin
          st_d  = RX_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      nib_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      nib_q  <= nib_d;
      sync_q <= sync_d;
    end
  end

  assign nib  = nib_q;
  assign sync = sync_q;
endmodule

// File: rtl/nibble_cell_if.sv
module nibble_cell_if #(
  parameter int NPORTS     = 4,
  parameter int CELL_BYTES = 53
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORTS-1:0]     tx_room,
  output logic [NPORTS-1:0]     tx_xclk,
  input  logic [4*NPORTS-1:0]   tx_td,
  input  logic [NPORTS-1:0]     tx_sync,
  output logic [NPORTS-1:0]     txc_we,
  output logic [8*NPORTS-1:0]   txc_byte,
  output logic [NPORTS-1:0]     txc_sop,
  output logic [NPORTS-1:0]     txc_eop,
  output logic [NPORTS-1:0]     txc_abort,
  input  logic [NPORTS-1:0]     rx_pull,
  output logic [4*NPORTS-1:0]   rx_nib,
  output logic [NPORTS-1:0]     rx_sync,
  input  logic [NPORTS-1:0]     rxc_avail,
  input  logic [8*NPORTS-1:0]   rxc_byte,
  output logic [NPORTS-1:0]     rxc_pop
);
  logic rst_q;

  nci_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    nci_tx_port #(.CELL_BYTES(CELL_BYTES)) u_tx (
      .clk   (clk),
      .rst_n (rst_q),
      .room  (tx_room[p]),
      .td    (tx_td[4*p +: 4]),
      .sync  (tx_sync[p]),
      .xclk  (tx_xclk[p]),
      .we    (txc_we[p]),
      .data  (txc_byte[8*p +: 8]),
      .sop   (txc_sop[p]),
      .eop   (txc_eop[p]),
      .abort (txc_abort[p])
    );
    nci_rx_port #(.CELL_BYTES(CELL_BYTES)) u_rx (
      .clk   (clk),
      .rst_n (rst_q),
      .pull  (rx_pull[p]),
      .avail (rxc_avail[p]),
      .head  (rxc_byte[8*p +: 8]),
      .nib   (rx_nib[4*p +: 4]),
      .sync  (rx_sync[p]),
      .pop   (rxc_pop[p])
    );
  end
endmodule

// File: rtl/nci_checker.sv
module nci_checker #(
  parameter int NPORTS     = 4,
  parameter int CELL_BYTES = 53
) (
  input logic                clk,
  input logic                rst_q,
  input logic [NPORTS-1:0]   tx_room,
  input logic [NPORTS-1:0]   tx_xclk,
  input logic [NPORTS-1:0]   tx_sync,
  input logic [NPORTS-1:0]   txc_we,
  input logic [NPORTS-1:0]   txc_sop,
  input logic [NPORTS-1:0]   txc_eop,
  input logic [NPORTS-1:0]   txc_abort,
  input logic [NPORTS-1:0]   rx_pull,
  input logic [4*NPORTS-1:0] rx_nib,
  input logic [NPORTS-1:0]   rx_sync,
  input logic [NPORTS-1:0]   rxc_avail,
  input logic [NPORTS-1:0]   rxc_pop
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    assert_strobe_follows_room_R1: assert property (@(posedge clk) disable iff (!rst_q)
      $past(rst_q) |-> (tx_xclk[p] == $past(tx_room[p])));
    assert_write_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_q)
      txc_we[p] |-> $past(tx_xclk[p]) && !$past(tx_sync[p]));
    assert_marks_with_write_R3: assert property (@(posedge clk) disable iff (!rst_q)
      (txc_sop[p] || txc_eop[p]) |-> txc_we[p]);
    assert_abort_from_frame_R5: assert property (@(posedge clk) disable iff (!rst_q)
      txc_abort[p] |-> $past(tx_xclk[p]) && $past(tx_sync[p]) && !txc_we[p]);
    assert_rx_frame_cause_R8: assert property (@(posedge clk) disable iff (!rst_q)
      rx_sync[p] |-> $past(rx_pull[p]) && $past(rxc_avail[p]) && (rx_nib[4*p +: 4] == 4'h0));
    assert_pop_needs_pull_R9: assert property (@(posedge clk) disable iff (!rst_q)
      rxc_pop[p] |-> rx_pull[p]);
    assert_rx_frame_single_R10: assert property (@(posedge clk) disable iff (!rst_q)
      rx_sync[p] |=> !rx_sync[p]);
    assert_nib_held_R10: assert property (@(posedge clk) disable iff (!rst_q)
      !$past(rx_pull[p]) && $past(rst_q) |-> $stable(rx_nib[4*p +: 4]));
  end
endmodule

bind nibble_cell_if nci_checker #(.NPORTS(NPORTS), .CELL_BYTES(CELL_BYTES)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .tx_room   (tx_room),
  .tx_xclk   (tx_xclk),
  .tx_sync   (tx_sync),
  .txc_we    (txc_we),
  .txc_sop   (txc_sop),
  .txc_eop   (txc_eop),
  .txc_abort (txc_abort),
  .rx_pull   (rx_pull),
  .rx_nib    (rx_nib),
  .rx_sync   (rx_sync),
  .rxc_avail (rxc_avail),
  .rxc_pop   (rxc_pop)
);

// File: tb/tb_nibble_cell_if.sv
module tb_nibble_cell_if;
  localparam int NP = 3;
  localparam int CB = 3;
  localparam int NIBS = 2 * CB;
  localparam int CYCLES = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]   tx_room = '0, tx_sync = '0, rx_pull = '0, rxc_avail = '0;
  logic [4*NP-1:0] tx_td = '0;
  logic [8*NP-1:0] rxc_byte = '0;
  logic [NP-1:0]   tx_xclk, txc_we, txc_sop, txc_eop, txc_abort, rx_sync, rxc_pop;
  logic [8*NP-1:0] txc_byte;
  logic [4*NP-1:0] rx_nib;

  nibble_cell_if #(.NPORTS(NP), .CELL_BYTES(CB)) dut (
    .clk(clk), .rst_n(rst_n), .tx_room(tx_room), .tx_xclk(tx_xclk), .tx_td(tx_td),
    .tx_sync(tx_sync), .txc_we(txc_we), .txc_byte(txc_byte), .txc_sop(txc_sop),
    .txc_eop(txc_eop), .txc_abort(txc_abort), .rx_pull(rx_pull), .rx_nib(rx_nib),
    .rx_sync(rx_sync), .rxc_avail(rxc_avail), .rxc_byte(rxc_byte), .rxc_pop(rxc_pop));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int n_abort = 0;
  int n_eop = 0;
  int n_rxcell = 0;

  // bench model state per port
  int         m_st[NP];
  int         m_cnt[NP];
  logic [3:0] m_hi[NP];
  logic       e_xclk[NP], e_we[NP], e_sop[NP], e_eop[NP], e_ab[NP];
  logic [7:0] e_byte[NP];
  int         r_st[NP];
  int         r_cnt[NP];
  int         r_idx[NP];
  logic [3:0] e_nib[NP];
  logic       e_rsync[NP];

  function automatic logic [7:0] head_of(input int p, input int idx);
    return 8'((p * 37 + idx * 11 + 5) & 255);
  endfunction

  task automatic check(input string tag, input int p, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s port %0d actual %0h expected %0h at %0t", tag, p, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    for (int p = 0; p < NP; p++) begin
      check("R1 R11 xclk", p, int'(tx_xclk[p]), int'(e_xclk[p]));
      check("R2 R4 R6 we", p, int'(txc_we[p]), int'(e_we[p]));
      if (e_we[p]) check("R2 byte", p, int'(txc_byte[8*p +: 8]), int'(e_byte[p]));
      check("R3 sop", p, int'(txc_sop[p]), int'(e_sop[p]));
      check("R3 eop", p, int'(txc_eop[p]), int'(e_eop[p]));
      check("R5 abort", p, int'(txc_abort[p]), int'(e_ab[p]));
      check("R7 R8 R10 rx_sync", p, int'(rx_sync[p]), int'(e_rsync[p]));
      check("R9 R10 rx_nib", p, int'(rx_nib[4*p +: 4]), int'(e_nib[p]));
    end
  endtask

  task automatic model_init();
    for (int p = 0; p < NP; p++) begin
      m_st[p] = 0; m_cnt[p] = 0; m_hi[p] = '0;
      e_xclk[p] = 0; e_we[p] = 0; e_sop[p] = 0; e_eop[p] = 0; e_ab[p] = 0; e_byte[p] = '0;
      r_st[p] = 0; r_cnt[p] = 0; r_idx[p] = 0; e_nib[p] = '0; e_rsync[p] = 0;
    end
  endtask

  // advance the model across one posedge; returns expected pop per port
  task automatic model_step(output logic [NP-1:0] pop);
    for (int p = 0; p < NP; p++) begin
      logic [3:0] nb;
      logic [7:0] hb;
      nb = tx_td[4*p +: 4];
      e_we[p] = 0; e_sop[p] = 0; e_eop[p] = 0; e_ab[p] = 0;
      if (e_xclk[p]) begin
        if (tx_sync[p]) begin
          e_ab[p] = (m_st[p] == 2);
          if (e_ab[p]) n_abort++;
          m_st[p] = 1; m_cnt[p] = 0;
        end else if (m_st[p] != 0) begin
          if (m_cnt[p] % 2 == 0) m_hi[p] = nb;
          else begin
            e_we[p] = 1; e_byte[p] = {m_hi[p], nb};
            e_sop[p] = (m_cnt[p] == 1); e_eop[p] = (m_cnt[p] == NIBS - 1);
            if (e_eop[p]) n_eop++;
          end
          if (m_cnt[p] == NIBS - 1) begin m_st[p] = 0; m_cnt[p] = 0; end
          else begin m_st[p] = 2; m_cnt[p]++; end
        end
      end
      e_xclk[p] = tx_room[p];
      pop[p] = 1'b0;
      e_rsync[p] = 0;
      if (rx_pull[p]) begin
        if (r_st[p] == 0) begin
          if (rxc_avail[p]) begin
            e_rsync[p] = 1; e_nib[p] = '0; r_st[p] = 1; r_cnt[p] = 0; n_rxcell++;
          end
        end else begin
          hb = head_of(p, r_idx[p]);
          e_nib[p] = (r_cnt[p] % 2 == 1) ? hb[3:0] : hb[7:4];
          pop[p] = (r_cnt[p] % 2 == 1);
          if (r_cnt[p] == NIBS - 1) begin r_st[p] = 0; r_cnt[p] = 0; end
          else r_cnt[p]++;
        end
      end
    end
  endtask

  task automatic drive_random(input int cyc);
    for (int p = 0; p < NP; p++) begin
      int room_pct;
      room_pct = (p == 0) ? 95 : ((p == 1) ? 70 : 50);
      tx_room[p] = ($urandom % 100) < room_pct;
      tx_td[4*p +: 4] = 4'($urandom);
      if (e_xclk[p]) tx_sync[p] = (m_st[p] == 0) ? (($urandom % 3) != 0) : (($urandom % 7) == 0);
      else tx_sync[p] = ($urandom % 2) != 0;
      rx_pull[p] = ($urandom % 100) < ((p == 2) ? 40 : 75);
      rxc_avail[p] = ($urandom % 100) < ((cyc / 500) % 2 == 0 ? 60 : 10);
      rxc_byte[8*p +: 8] = head_of(p, r_idx[p]);
    end
  endtask

  task automatic run_cycle(input int cyc);
    logic [NP-1:0] ep;
    check_outputs();
    drive_random(cyc);
    #1;
    model_step(ep);
    for (int p = 0; p < NP; p++) begin
      check("R9 pop", p, int'(rxc_pop[p]), int'(ep[p]));
      if (ep[p]) r_idx[p]++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    model_init();
    repeat (3) @(negedge clk);
    // reset state R1
    for (int p = 0; p < NP; p++) begin
      check("R1 reset xclk", p, int'(tx_xclk[p]), 0);
      check("R1 reset we", p, int'(txc_we[p]), 0);
      check("R1 reset abort", p, int'(txc_abort[p]), 0);
      check("R1 reset rx_sync", p, int'(rx_sync[p]), 0);
      check("R1 reset rx_nib", p, int'(rx_nib[4*p +: 4]), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed: port 0 cell with mid-cell frame (R5), then a full cell (R2 R3)
    begin
      logic [NP-1:0] ep;
      int seq_sync[14] = '{0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0};
      for (int i = 0; i < 14; i++) begin
        check_outputs();
        tx_room = '1;
        tx_sync = '0;
        tx_sync[0] = seq_sync[i][0];
        tx_td = {NP{4'(i + 3)}};
        rx_pull = '1;
        rxc_avail = '1;
        for (int p = 0; p < NP; p++) rxc_byte[8*p +: 8] = head_of(p, r_idx[p]);
        #1;
        model_step(ep);
        for (int p = 0; p < NP; p++) begin
          check("R9 pop", p, int'(rxc_pop[p]), int'(ep[p]));
          if (ep[p]) r_idx[p]++;
        end
        @(negedge clk);
      end
    end

    for (int c = 0; c < CYCLES; c++) run_cycle(c);
    check_outputs();

    checks++;
    if (n_abort == 0 || n_eop == 0 || n_rxcell == 0) begin
      errors++;
      $display("FAIL R5 R3 R8 coverage actual %0d/%0d/%0d expected nonzero", n_abort, n_eop, n_rxcell);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule